// File: doc/BRIEF.md
# Serial Receiver with Status Flags

This block receives asynchronous serial characters from a single input line and keeps them in a receive data register together with three status flags: data-full, line-idle and overrun. The line is sampled by an oversampling tick supplied from outside, sixteen ticks per bit. A mode input selects 8 or 9 data bits per character. The ninth bit, when present, is held in a separate high data bit.

Software sees the flags on a status output and the character on the data outputs. Two read strobes model the side effects of register reads. A flag is cleared by a status read taken while the flag is set, followed later by a read of the low data byte. Two maskable interrupt outputs report the flags: one for data-full and overrun, one for line-idle.

Top module: `uart_rx_flags`

## Requirements
- R1: The line is sampled on each `os_tick`, 16 ticks per bit. A start bit is accepted only if the line is still low at its mid-bit sample, 8 ticks after the first low sample. A low pulse shorter than that yields no character. Data bits are taken at mid-bit, least significant first: 8 bits when `nine_bit_mode` is 0, 9 bits when it is 1.
- R2: A character whose stop bit is sampled high is stored. Bits 7..0 go to `data_lo`. Bit 8 goes to `data_hi`, which is 0 in 8-bit mode. Status bit 0 (data-full) is set.
- R3: A character whose stop bit is sampled low is discarded. No flag changes and the data outputs keep their value.
- R4: A flag clears only when `rd_status` is pulsed while that flag is set and `rd_data_lo` is pulsed afterwards. A `rd_data_lo` pulse with no earlier status read leaves all flags unchanged.
- R5: Status bit 1 (idle) is set when the line has stayed high for 10 bit times after its last low sample in 8-bit mode, or 11 bit times in 9-bit mode.
- R6: After the idle flag has been set, it is not set again until a new character has been stored into the data register.
- R7: If a character completes with a valid stop bit while data-full is still set, status bit 2 (overrun) is set. The new character is discarded and the data outputs are unchanged.
- R8: `rx_irq` is high when `rx_irq_en` is 1 and data-full or overrun is set. `idle_irq` is high when `idle_irq_en` is 1 and idle is set.
- R9: After reset, all flags, the data outputs and both interrupts are 0. The idle flag cannot be set before the first character has been stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_line | input | 1 | Serial input line, idle high |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_irq_en | input | 1 | Enable for the data-full and overrun interrupt |
| idle_irq_en | input | 1 | Enable for the idle interrupt |
| rd_status | input | 1 | One-cycle strobe: status register read |
| rd_data_lo | input | 1 | One-cycle strobe: low data byte read |
| status_flags | output | 3 | {overrun, idle, data-full} |
| data_lo | output | 8 | Received bits 7..0 |
| data_hi | output | 1 | Received bit 8 |
| rx_irq | output | 1 | Data-full or overrun interrupt request |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
The hardest state to reach from the ports is the idle detector's arming. It needs a stored character, then an unbroken high stretch of exactly the mode's bit count, then a clear, and then a second long high stretch that must not set the flag again. The stimulus sends characters whose last data bit is 0, so the final low sample falls at a known cycle. It then samples the idle flag half a bit before and half a bit after the 10- or 11-bit threshold. The stimulus gets to overrun by sending two valid characters with no read in between.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver: deframer states and the flag set.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef struct packed {
        logic ovr;
        logic idle;
        logic full;
    } rx_flags_t;

endpackage

// File: rtl/rx_deframer.sv
// Character deframer.
// Hunts for a start edge, confirms it at mid-bit, samples 8 or 9 data bits
// LSB first at mid-bit, and checks the stop bit. A valid character raises
// frame_valid for one clock. A low stop bit sends the FSM to a wait state
// until the line returns high.
// Assumes: rxd is already synchronous to clk; tick comes OVERSAMPLE times per bit.
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       nine_bit,
    output logic       frame_valid,
    output logic [8:0] frame_data
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID_T  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST_T = CW'(OVERSAMPLE - 1);

    rx_state_e      state_q;
    logic [CW-1:0]  tcnt_q;
    logic [3:0]     bidx_q;
    logic [8:0]     shreg_q;
    logic           valid_q;
    logic [3:0]     last_idx;

    assign last_idx    = nine_bit ? 4'd8 : 4'd7;
    assign frame_valid = valid_q;
    assign frame_data  = shreg_q;

    // Deframing state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    RX_HUNT: begin
                        if (!rxd) begin
                            state_q <= RX_START;
                            tcnt_q  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt_q == MID_T) begin
                            tcnt_q <= '0;
                            if (!rxd) begin
                                state_q <= RX_DATA;
                                bidx_q  <= '0;
                                shreg_q <= '0;
                            end else begin
                                state_q <= RX_HUNT;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt_q == LAST_T) begin
                            tcnt_q <= '0;
                            shreg_q[bidx_q] <= rxd;
                            if (bidx_q == last_idx) state_q <= RX_STOP;
                            else                    bidx_q  <= bidx_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt_q == LAST_T) begin
                            tcnt_q <= '0;
                            if (rxd) begin
                                valid_q <= 1'b1;
                                state_q <= RX_HUNT;
                            end else begin
                                state_q <= RX_BREAK;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_BREAK: begin
                        if (rxd) state_q <= RX_HUNT;
                    end
                    default: state_q <= RX_HUNT;
                endcase
            end
        end
    end

    // R1
    frame_ends_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> state_q == RX_HUNT);

    // R1
    bit_index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RX_DATA |-> bidx_q <= 4'd8);

endmodule

// File: rtl/rx_idle_det.sv
// Idle-line detector.
// Counts whole bit times of continuous high level. A low sample restarts
// both the bit-time prescaler and the count, so the count is measured from
// the last low sample. Fires one pulse when the mode's threshold is reached.
// The detector must be armed by a stored character, and firing disarms it.
// Assumes: rxd synchronous to clk; arm is a single-cycle pulse.
module rx_idle_det #(
    parameter int OVERSAMPLE  = 16,
    parameter int IDLE_BITS_8 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic nine_bit,
    input  logic arm,
    output logic idle_hit
);
    localparam int PW      = $clog2(OVERSAMPLE);
    localparam int THR9    = IDLE_BITS_8 + 1;
    localparam int NW      = $clog2(THR9 + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(OVERSAMPLE - 1);

    logic [PW-1:0] pre_q;
    logic [NW-1:0] bits_q;
    logic [NW-1:0] thr;
    logic          armed_q;
    logic          hit_q;

    assign thr      = nine_bit ? NW'(THR9) : NW'(IDLE_BITS_8);
    assign idle_hit = hit_q;

    // Prescaler and high-bit-time counter, both restarted by a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            bits_q <= '0;
        end else if (tick) begin
            if (!rxd) begin
                pre_q  <= '0;
                bits_q <= '0;
            end else begin
                pre_q <= pre_q + 1'b1;
                if (pre_q == PRE_LAST && bits_q < thr) bits_q <= bits_q + 1'b1;
            end
        end
    end

    // Arming and the single idle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (arm) begin
                armed_q <= 1'b1;
            end else if (armed_q && bits_q >= thr) begin
                armed_q <= 1'b0;
                hit_q   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_flag_unit.sv
// Receive data register and status flags.
// Stores valid characters unless data-full is still set, in which case it
// raises overrun and keeps the old data. A status read records which flags
// were set. A later low-byte data read clears exactly those flags.
// Assumes: frame_valid and idle_hit are single-cycle pulses.
module rx_flag_unit
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_valid,
    input  logic [8:0] frame_data,
    input  logic       idle_hit,
    input  logic       rd_status,
    input  logic       rd_data_lo,
    output rx_flags_t  flags,
    output logic [8:0] data_q,
    output logic       store_evt
);
    rx_flags_t  flags_q, armed_q, clr, flags_d;
    logic [8:0] data_r;

    assign flags  = flags_q;
    assign data_q = data_r;

    // Next flag values: armed clears first, then new set events.
    always_comb begin
        clr       = rd_data_lo ? armed_q : '0;
        flags_d   = flags_q & ~clr;
        store_evt = 1'b0;
        if (frame_valid) begin
            if (flags_d.full) flags_d.ovr = 1'b1;
            else begin
                flags_d.full = 1'b1;
                store_evt    = 1'b1;
            end
        end
        if (idle_hit) flags_d.idle = 1'b1;
    end

    // Flag, read-arm and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
            data_r  <= '0;
        end else begin
            flags_q <= flags_d;
            if (rd_status)       armed_q <= flags_q;
            else if (rd_data_lo) armed_q <= '0;
            if (store_evt)       data_r  <= frame_data;
        end
    end

    // R2
    store_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_evt |=> flags_q.full && data_r == $past(frame_data));

    // R7
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && !store_evt |=> flags_q.ovr && $stable(data_r));

    // R4
    full_clears_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q.full) |-> $past(rd_data_lo));

    // R4
    ovr_clears_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q.ovr) |-> $past(rd_data_lo));

endmodule

// File: rtl/uart_rx_flags.sv
// Serial receiver top: line synchronizer, deframer, idle detector and
// flag unit, plus the interrupt masks.
// Assumes: os_tick is a single-cycle pulse at 16x the bit rate; read strobes
// are single-cycle pulses.
module uart_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_BITS_8 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic       nine_bit_mode,
    input  logic       rx_irq_en,
    input  logic       idle_irq_en,
    input  logic       rd_status,
    input  logic       rd_data_lo,
    output logic [2:0] status_flags,
    output logic [7:0] data_lo,
    output logic       data_hi,
    output logic       rx_irq,
    output logic       idle_irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic       rxd_s;
    logic       frame_valid;
    logic [8:0] frame_data;
    logic       idle_hit;
    logic       store_evt;
    rx_flags_t  flags;
    logic [8:0] data_q;

    // Two-or-more-flop synchronizer for the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end
    assign rxd_s = sync_q[SYNC_STAGES-1];

    rx_deframer #(.OVERSAMPLE(OVERSAMPLE)) u_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .rxd         (rxd_s),
        .nine_bit    (nine_bit_mode),
        .frame_valid (frame_valid),
        .frame_data  (frame_data)
    );

    rx_idle_det #(.OVERSAMPLE(OVERSAMPLE), .IDLE_BITS_8(IDLE_BITS_8)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rxd      (rxd_s),
        .nine_bit (nine_bit_mode),
        .arm      (store_evt),
        .idle_hit (idle_hit)
    );

    rx_flag_unit u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .idle_hit    (idle_hit),
        .rd_status   (rd_status),
        .rd_data_lo  (rd_data_lo),
        .flags       (flags),
        .data_q      (data_q),
        .store_evt   (store_evt)
    );

    assign status_flags = flags;
    assign data_lo      = data_q[7:0];
    assign data_hi      = data_q[8];
    assign rx_irq       = rx_irq_en && (flags.full || flags.ovr);
    assign idle_irq     = idle_irq_en && flags.idle;

    // R6
    idle_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |-> !store_evt);

endmodule

// File: tb/tb_uart_rx_flags.sv
module tb_uart_rx_flags;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b1;
    logic rx_line = 1'b1;
    logic nine_bit_mode = 1'b0;
    logic rx_irq_en = 1'b0;
    logic idle_irq_en = 1'b0;
    logic rd_status = 1'b0;
    logic rd_data_lo = 1'b0;
    logic [2:0] status_flags;
    logic [7:0] data_lo;
    logic data_hi;
    logic rx_irq;
    logic idle_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // {nine_bit, data[8:0]}; in 8-bit mode bit 8 is not sent
    localparam logic [9:0] VEC [7] = '{
        {1'b0, 9'h055}, {1'b0, 9'h1A3}, {1'b0, 9'h000}, {1'b0, 9'h0FE},
        {1'b1, 9'h12C}, {1'b1, 9'h0F0}, {1'b1, 9'h181}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_flags dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .nine_bit_mode(nine_bit_mode), .rx_irq_en(rx_irq_en),
        .idle_irq_en(idle_irq_en), .rd_status(rd_status), .rd_data_lo(rd_data_lo),
        .status_flags(status_flags), .data_lo(data_lo), .data_hi(data_hi),
        .rx_irq(rx_irq), .idle_irq(idle_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic nine, input logic [8:0] d, input logic stop_ok);
        @(negedge clk);
        rx_line = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_line = d[i];
            wait_clks(BIT_CLKS);
        end
        rx_line = stop_ok;
        wait_clks(BIT_CLKS);
        rx_line = 1'b1;
    endtask

    task automatic pulse_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk) rd_data_lo = 1'b1;
        @(negedge clk) rd_data_lo = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clks(5);
        // R9 reset state
        check("R9 flags", 16'(status_flags), 16'h0);
        check("R9 data", {7'b0, data_hi, data_lo}, 16'h0);
        check("R9 irq", {14'b0, rx_irq, idle_irq}, 16'h0);
        rst_n = 1'b1;
        idle_irq_en = 1'b1;
        // R9 idle stays disarmed before the first stored character
        wait_clks(12 * BIT_CLKS);
        check("R9 idle disarmed", 16'(status_flags[1]), 16'h0);

        // R1 short low glitch is not a start bit
        @(negedge clk) rx_line = 1'b0;
        wait_clks(5);
        rx_line = 1'b1;
        wait_clks(3 * BIT_CLKS);
        check("R1 glitch rejected", 16'(status_flags), 16'h0);

        // R3 low stop bit discards the character
        send_frame(1'b0, 9'h05A, 1'b0);
        wait_clks(2 * BIT_CLKS);
        check("R3 no flag", 16'(status_flags), 16'h0);
        check("R3 data kept", {7'b0, data_hi, data_lo}, 16'h0);

        // R1 R2 table walk (rx_irq_en = 0 also exercises R8 masking)
        idle_irq_en = 1'b0;
        for (int v = 0; v < 7; v++) begin
            nine_bit_mode = VEC[v][9];
            send_frame(VEC[v][9], VEC[v][8:0], 1'b1);
            check("R2 full set", 16'(status_flags), 16'h1);
            check("R1 data_lo", 16'(data_lo), 16'(VEC[v][7:0]));
            check("R2 data_hi", 16'(data_hi), 16'(VEC[v][9] & VEC[v][8]));
            check("R8 rx_irq masked", 16'(rx_irq), 16'h0);
            pulse_status();
            pulse_data();
            check("R4 cleared", 16'(status_flags), 16'h0);
        end

        // R4 data read without status read leaves flags
        nine_bit_mode = 1'b0;
        send_frame(1'b0, 9'h03C, 1'b1);
        pulse_data();
        check("R4 no status read", 16'(status_flags), 16'h1);
        pulse_status();
        pulse_data();
        check("R4 status then data", 16'(status_flags), 16'h0);

        // R7 overrun with R8 interrupt
        rx_irq_en = 1'b1;
        send_frame(1'b0, 9'h011, 1'b1);
        check("R8 rx_irq full", 16'(rx_irq), 16'h1);
        send_frame(1'b0, 9'h022, 1'b1);
        check("R7 overrun flag", 16'(status_flags), 16'h5);
        check("R7 data kept", 16'(data_lo), 16'h11);
        pulse_status();
        pulse_data();
        check("R7 cleared", 16'(status_flags & 3'b101), 16'h0);
        check("R7 data after clear", 16'(data_lo), 16'h11);
        check("R8 rx_irq low", 16'(rx_irq), 16'h0);
        rx_irq_en = 1'b0;

        // R5 idle threshold in 8-bit mode, about 147 clocks after return
        idle_irq_en = 1'b1;
        send_frame(1'b0, 9'h055, 1'b1);
        pulse_status();
        pulse_data();
        wait_clks(132);
        check("R5 idle not yet 8b", 16'(status_flags[1]), 16'h0);
        wait_clks(19);
        check("R5 idle set 8b", 16'(status_flags[1]), 16'h1);
        check("R8 idle_irq", 16'(idle_irq), 16'h1);
        pulse_status();
        pulse_data();
        check("R4 idle cleared", 16'(status_flags[1]), 16'h0);
        // R6 no re-arm without a stored character
        wait_clks(15 * BIT_CLKS);
        check("R6 idle stays clear", 16'(status_flags[1]), 16'h0);

        // R5 idle threshold in 9-bit mode, about 163 clocks after return
        idle_irq_en = 1'b0;
        nine_bit_mode = 1'b1;
        send_frame(1'b1, 9'h0AA, 1'b1);
        pulse_status();
        pulse_data();
        wait_clks(148);
        check("R5 idle not yet 9b", 16'(status_flags[1]), 16'h0);
        wait_clks(19);
        check("R5 idle set 9b", 16'(status_flags[1]), 16'h1);
        check("R8 idle_irq masked", 16'(idle_irq), 16'h0);

        finish_run();
    end
endmodule